// File: doc/BRIEF.md
# Programmable debug link clock generator

This block produces the outgoing clock of a serial debug link by dividing the system bus clock by a ratio that host software programs through a 16-bit register field. The link clock is made entirely from bus-clock cycles, so when the bus clock speeds up or slows down, the link rate follows it in proportion. After reset the ratio is at its largest value. This gives the slowest link rate until software picks a faster one, and software must never program a ratio below two.

The same block launches the outgoing 4-bit nibble and its sync bit. New values appear on the bus cycle in which the link clock falls, so they are settled half a link period before the next rising edge. Nibbles arrive on a valid/ready stream. The block asserts `in_ready` for exactly one bus cycle per link period: the last cycle of the high phase. A source that holds `in_valid` high simply waits for that cycle, and nothing is lost. If `in_valid` is low in that cycle, the block sends an idle slot with nibble 0 and sync 0. A one-cycle `lclk_rise` strobe marks every rising edge so that a shifter upstream can prepare the next nibble.

A standby input stops the link clock at a low level. While standby is held, the block shows no edges, never asserts `in_ready` and keeps the launched data where it is.

Top module: `dlk_clk_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it drops, `lclk`, `lclk_rise`, `out_data` and `out_sync` are 0. The divider field resets to 65535, so the first period after reset is 32768 bus cycles low followed by 32767 bus cycles high.
- R2: When `cfg_wdata` is written with a value of 0 or 1, the divider field stores 2, and the resulting link period is one cycle low and one cycle high.
- R3: For a ratio N, each link period lasts N bus cycles. It starts with a low phase of ceil(N/2) cycles and ends with a high phase of floor(N/2) cycles.
- R4: A write on `cfg_we` leaves the period in progress unchanged. The new ratio applies from the next period boundary that occurs at least one cycle after the write.
- R5: While `stby` is high, `lclk` and `lclk_rise` stay 0. After `stby` drops, the first rising edge of `lclk` comes ceil(N/2) bus cycles after the last clock edge at which `stby` was sampled high. N is the register value current at that edge, so a write made during standby applies from the release.
- R6: `in_ready` is high only in the last bus cycle of a period and never during standby. At the clock edge that ends that cycle, `out_data` and `out_sync` take `in_data` and `in_sync` if `in_valid` is high, and take 0 and 0 if it is low. At no other edge do they change.
- R7: `lclk_rise` is high for exactly the first bus cycle of each high phase of `lclk` and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Divider field write enable |
| cfg_wdata | input | 16 | Divider value to write |
| stby | input | 1 | Standby: stop the link clock low |
| in_valid | input | 1 | Nibble stream valid |
| in_ready | output | 1 | Nibble stream ready, one cycle per period |
| in_data | input | 4 | Nibble to launch |
| in_sync | input | 1 | Sync bit to launch with the nibble |
| lclk | output | 1 | Generated link clock |
| lclk_rise | output | 1 | Strobe on the first high cycle of `lclk` |
| out_data | output | 4 | Launched nibble |
| out_sync | output | 1 | Launched sync bit |

## Verification
A corrupted period counter shows up at `lclk` at its next expected edge, no more than one period late. The same fault moves `in_ready` to the wrong cycle, which the reference model catches in that cycle. A wrong latched ratio goes unseen until the next period boundary. Because the model compares every bus cycle, the fault is reported at the first edge that lands in the wrong place. A launch register that loads outside the period boundary changes `out_data` while `lclk` is high, and this is caught in the same cycle.

// File: rtl/dlk_pkg.sv
package dlk_pkg;
  localparam int unsigned DLK_DIV_W  = 16;
  localparam int unsigned DLK_DIV_MIN = 2;
  localparam int unsigned DLK_NIB_W  = 4;
endpackage

// File: rtl/dlk_div_reg.sv
module dlk_div_reg #(
  parameter int unsigned DIV_W   = dlk_pkg::DLK_DIV_W,
  parameter int unsigned DIV_MIN = dlk_pkg::DLK_DIV_MIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_wdata,
  output logic [DIV_W-1:0] div_eff
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(DIV_MIN);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)
      div_q <= '1;
    else if (cfg_we)
      div_q <= (cfg_wdata < FLOOR) ? FLOOR : cfg_wdata;
  end

  assign div_eff = div_q;

  // R2: a stored value is never below the floor
  a_r2_store_floor: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (div_q >= FLOOR));
endmodule

// File: rtl/dlk_phase_gen.sv
module dlk_phase_gen #(
  parameter int unsigned DIV_W = dlk_pkg::DLK_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stby,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             wrap,
  output logic             lclk,
  output logic             lclk_rise
);
  localparam int unsigned CW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] ratio_q, ratio_n;
  logic [CW-1:0]    low_n;
  logic             lclk_q, lclk_n, rise_q;

  // last cycle of the current period
  assign wrap = !stby && (cnt_q == (ratio_q - DIV_W'(1)));

  always_comb begin
    if (stby || wrap) begin
      cnt_n   = '0;
      ratio_n = ratio_in;
    end else begin
      cnt_n   = cnt_q + DIV_W'(1);
      ratio_n = ratio_q;
    end
    low_n  = ({1'b0, ratio_n} + CW'(1)) >> 1;
    lclk_n = !stby && ({1'b0, cnt_n} >= low_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= '1;
      lclk_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ratio_q <= ratio_n;
      lclk_q  <= lclk_n;
      rise_q  <= lclk_n && !lclk_q;
    end
  end

  assign lclk      = lclk_q;
  assign lclk_rise = rise_q;

  // R2: the ratio in use never drops below two
  a_r2_ratio_floor: assert property (@(posedge clk) disable iff (rst)
    ratio_q >= DIV_W'(dlk_pkg::DLK_DIV_MIN));
  // R4: the ratio only changes at a boundary or in standby
  a_r4_ratio_hold: assert property (@(posedge clk) disable iff (rst)
    (!stby && !wrap) |=> $stable(ratio_q));
  // R5: standby holds the clock low with no strobe
  a_r5_stop_low: assert property (@(posedge clk) disable iff (rst)
    stby |=> (!lclk_q && !rise_q));
  // R3: every period ends in its high phase
  a_r3_wrap_high: assert property (@(posedge clk) disable iff (rst)
    wrap |-> lclk_q);
endmodule

// File: rtl/dlk_launch.sv
module dlk_launch #(
  parameter int unsigned NIB_W = dlk_pkg::DLK_NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NIB_W-1:0] in_data,
  input  logic             in_sync,
  output logic [NIB_W-1:0] out_data,
  output logic             out_sync
);
  logic [NIB_W-1:0] data_q;
  logic             sync_q;

  assign in_ready = wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      sync_q <= 1'b0;
    end else if (wrap) begin
      data_q <= in_valid ? in_data : '0;
      sync_q <= in_valid && in_sync;
    end
  end

  assign out_data = data_q;
  assign out_sync = sync_q;

  // R6: launched values hold between period boundaries
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(data_q) && $stable(sync_q)));
endmodule

// File: rtl/dlk_clk_gen.sv
module dlk_clk_gen #(
  parameter int unsigned DIV_W   = dlk_pkg::DLK_DIV_W,
  parameter int unsigned DIV_MIN = dlk_pkg::DLK_DIV_MIN,
  parameter int unsigned NIB_W   = dlk_pkg::DLK_NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             stby,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NIB_W-1:0] in_data,
  input  logic             in_sync,
  output logic             lclk,
  output logic             lclk_rise,
  output logic [NIB_W-1:0] out_data,
  output logic             out_sync
);
  logic [DIV_W-1:0] div_eff;
  logic             wrap;

  dlk_div_reg #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_reg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .div_eff(div_eff)
  );

  dlk_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst(rst), .stby(stby), .ratio_in(div_eff),
    .wrap(wrap), .lclk(lclk), .lclk_rise(lclk_rise)
  );

  dlk_launch #(.NIB_W(NIB_W)) u_launch (
    .clk(clk), .rst(rst), .wrap(wrap), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sync(in_sync),
    .out_data(out_data), .out_sync(out_sync)
  );

  // R7: strobe marks exactly the rising edges
  a_r7_rise_marked: assert property (@(posedge clk) disable iff (rst)
    $rose(lclk) |-> lclk_rise);
  a_r7_rise_only: assert property (@(posedge clk) disable iff (rst)
    lclk_rise |-> $rose(lclk));
  // R6: launched nibble changes only together with a falling edge
  a_r6_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> $fell(lclk));
  // R6: no stream handshake in standby
  a_r6_no_ready_stby: assert property (@(posedge clk) disable iff (rst)
    stby |-> !in_ready);
endmodule

// File: tb/tb_dlk_clk_gen.sv
`timescale 1ns/1ps
module tb_dlk_clk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        stby = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_data = '0;
  logic        in_sync = 1'b0;
  logic        lclk, lclk_rise;
  logic [3:0]  out_data;
  logic        out_sync;

  always #4 clk = ~clk;

  dlk_clk_gen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stby(stby), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sync(in_sync), .lclk(lclk),
    .lclk_rise(lclk_rise), .out_data(out_data), .out_sync(out_sync)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit feed_en = 0;
  int item_k = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model, updated at every bus edge
  int m_reg, m_ratio, m_pos, m_data, m_sync, m_l, m_lprev;
  bit m_live = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_reg = 65535; m_ratio = 65535; m_pos = 0;
      m_data = 0; m_sync = 0; m_l = 0; m_lprev = 0; m_live = 1;
    end else begin
      bit endp;
      endp = !stby && (m_pos == m_ratio - 1);
      if (stby) begin
        m_pos = 0; m_ratio = m_reg;
      end else if (endp) begin
        m_pos = 0; m_ratio = m_reg;
        m_data = in_valid ? int'(in_data) : 0;
        m_sync = in_valid ? int'(in_sync) : 0;
      end else begin
        m_pos++;
      end
      if (cfg_we) m_reg = (cfg_wdata < 2) ? 2 : int'(cfg_wdata);
      m_lprev = m_l;
      m_l = (m_pos >= (m_ratio + 1) / 2) ? 1 : 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_live && !rst && !done) begin
      int exp_rdy;
      exp_rdy = (!stby && m_pos == m_ratio - 1) ? 1 : 0;
      chk(lclk == m_l, "R3", "lclk level", lclk, m_l);
      chk(lclk_rise == (m_l && !m_lprev), "R7", "rise strobe", lclk_rise, m_l && !m_lprev);
      chk(in_ready == exp_rdy, "R6", "in_ready", in_ready, exp_rdy);
      chk(out_data == m_data, "R6", "out_data", out_data, m_data);
      chk(out_sync == m_sync, "R6", "out_sync", out_sync, m_sync);
    end
  end

  // stream source: holds each item until it is taken
  always @(negedge clk) begin
    if (feed_en) begin
      if (in_valid && in_ready) item_k <= item_k + 1;
      in_valid <= 1'b1;
      in_data  <= (in_valid && in_ready) ? 4'(item_k + 1) : 4'(item_k);
      in_sync  <= (in_valid && in_ready) ? ((item_k + 1) % 4 == 0) : (item_k % 4 == 0);
    end else begin
      in_valid <= 1'b0;
    end
  end

  task automatic wr(int v);
    @(negedge clk);
    cfg_we <= 1'b1; cfg_wdata <= 16'(v);
    @(negedge clk);
    cfg_we <= 1'b0;
  endtask

  // called at a low cycle; counts the rest of that period
  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    while (lclk == 1'b0) begin lo++; @(negedge clk); end
    while (lclk == 1'b1) begin hi++; @(negedge clk); end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int lo, hi, hc, sc, rc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lclk == 1'b0, "R1", "lclk in reset", lclk, 0);
    chk(out_data == 4'd0 && out_sync == 1'b0, "R1", "data in reset", out_data, 0);
    rst <= 1'b0;
    feed_en <= 1'b1;
    // first period: reset ratio, with a write in its low phase (R4)
    lo = 0; hi = 0;
    while (lclk == 1'b0) begin
      lo++;
      if (lo == 1000) begin cfg_we <= 1'b1; cfg_wdata <= 16'd4; end
      if (lo == 1001) cfg_we <= 1'b0;
      @(negedge clk);
    end
    while (lclk == 1'b1) begin hi++; @(negedge clk); end
    chk(lo == 32768, "R1", "reset low phase", lo, 32768);
    chk(hi == 32767, "R1", "reset high phase", hi, 32767);
    chk(hi == 32767, "R4", "period during write unchanged", hi, 32767);
    measure(lo, hi);
    chk(lo == 2 && hi == 2, "R4", "new ratio 4 applied", lo * 10 + hi, 22);
    wr(5);
    measure(lo, hi);
    measure(lo, hi);
    chk(lo == 3 && hi == 2, "R3", "odd ratio 5 phases", lo * 10 + hi, 32);
    measure(lo, hi);
    chk(lo + hi == 5, "R3", "ratio 5 period", lo + hi, 5);
    wr(0);
    measure(lo, hi);
    measure(lo, hi);
    chk(lo == 1 && hi == 1, "R2", "write 0 acts as 2", lo * 10 + hi, 11);
    wr(1);
    measure(lo, hi);
    measure(lo, hi);
    chk(lo == 1 && hi == 1, "R2", "write 1 acts as 2", lo * 10 + hi, 11);
    wr(8);
    measure(lo, hi);
    measure(lo, hi);
    chk(lo == 4 && hi == 4, "R3", "even ratio 8 phases", lo * 10 + hi, 44);
    // standby with a write inside it (R5)
    stby <= 1'b1;
    hc = 0; sc = 0; rc = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 5) begin cfg_we <= 1'b1; cfg_wdata <= 16'd6; end
      if (i == 6) cfg_we <= 1'b0;
      if (i > 0) begin hc += lclk; sc += lclk_rise; rc += in_ready; end
    end
    chk(hc == 0, "R5", "lclk high in standby", hc, 0);
    chk(sc == 0, "R5", "strobes in standby", sc, 0);
    chk(rc == 0, "R6", "ready in standby", rc, 0);
    stby <= 1'b0;
    measure(lo, hi);
    chk(lo == 3 && hi == 3, "R5", "restart low phase with ratio 6", lo * 10 + hi, 33);
    // idle slot when the source has nothing (R6)
    wr(2);
    repeat (20) @(negedge clk);
    feed_en <= 1'b0;
    repeat (12) @(negedge clk);
    chk(out_data == 4'd0 && out_sync == 1'b0, "R6", "idle slot", out_data, 0);
    feed_en <= 1'b1;
    repeat (40) @(negedge clk);
    chk(item_k > 20, "R6", "items accepted", item_k, 21);
    done = 1;
    summary();
    $finish;
  end
endmodule